// File: doc/BRIEF.md
# Four-Channel Cycle-Stealing DMA Controller

This block moves data between memory locations on behalf of up to four independent channels, taking the shared memory bus one transfer at a time. Each channel is programmed through a small register window. The window holds a request-source selector, a mode, a unit size, a choice of which address side advances, a 16-bit transfer count, a reload value, and 24-bit source and destination addresses. A channel is started by a software kick or by a pulse on one of the peripheral request lines. The CPU interrupt masks do not gate these requests. The block never acknowledges or clears the requesting peripheral's flag.

A fixed-priority arbiter hands the bus to the lowest-numbered channel that has a pending request. That channel performs one read from its source address, then one write of the same unit to its destination. After the write the counter drops by one and the advancing address moves on. When the counter goes from one to zero, the block pulses that channel's interrupt line. In single mode the channel then stops. In repeat mode it reloads the count and keeps serving requests.

Top module: `dma4_steal`

## Requirements
- R1: After reset every channel reads back a zero control word and a zero count, and bus_req, irq and cfg_err are all low.
- R2: When several channels are eligible in the same cycle, they are served in order of channel number, lowest first.
- R3: The control word is laid out as follows: sel in bits 4:0, mode in bits 6:5, wide in bit 7, source-advance in bit 8, destination-advance in bit 9, and a write-only kick in bit 10. When sel is 31, writing the control word with the kick bit set requests one transfer. When sel is below NUM_PREQ, a one-cycle pulse on periph_req[sel] requests one transfer.
- R4: A channel holds at most one pending request. Extra requests that arrive while its transfer is in flight merge into that single pending request.
- R5: Mode 01 is single and mode 11 is repeat. Modes 00 and 10 disable the channel. A channel is served only when it is enabled and its count is nonzero.
- R6: A transfer takes one arbitration cycle, then a read at the source address, then a write of the read data at the destination address. The read and the write each hold bus_req, bus_we and bus_addr steady until bus_ready is high.
- R7: With wide=1 the unit is 16 bits and the advancing address grows by 2. With wide=0 the unit is bits 7:0 of the read data, bus_wdata[15:8] is zero, and the address grows by 1. Addresses wrap modulo 2^24.
- R8: Exactly one of source-advance and destination-advance must be set. If an enabled channel has both set or neither set, cfg_err for that channel goes high and the channel performs no transfers.
- R9: Each completed transfer decrements the count by one. irq for the channel pulses high for exactly one cycle, only on the step from 1 to 0.
- R10: When the count reaches 0, a single-mode channel stops. A repeat-mode channel loads its count from the reload register and continues.
- R11: Software writing a count of 0 stops the channel in single mode. In repeat mode it stops the channel only when the reload register is also 0; otherwise the count is loaded from the reload register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | {channel, register index}: 0 control, 1 count, 2 reload, 3 source, 4 destination |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| periph_req | input | 8 | Peripheral request pulses |
| bus_req | output | 1 | Bus access active |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_wide | output | 1 | 1 = 16-bit unit, 0 = 8-bit unit |
| bus_addr | output | 24 | Byte address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data |
| bus_ready | input | 1 | Access completes in this cycle |
| irq | output | 4 | Per-channel completion pulse |
| cfg_err | output | 4 | Per-channel illegal address-side setting |

## Verification
A request sampled at clock edge E0 wins arbitration at E1. With zero wait states, the read is on the bus between E1 and E2 and the write between E2 and E3. The count, the address and the irq pulse all change at E3. Each stall cycle delays everything after it by one edge. The bench drives inputs and samples outputs on the falling edge, and checks the read phase, the write phase, the irq pulse and its clearing one falling edge at a time. For tests that run whole sequences, it waits a fixed margin that is longer than the worst-case latency and only then reads back the registers and the write log.

// File: rtl/dma4_pkg.sv
`timescale 1ns/1ps
package dma4_pkg;
   typedef enum logic [1:0] {
      MODE_OFF    = 2'b00,
      MODE_SINGLE = 2'b01,
      MODE_RSVD   = 2'b10,
      MODE_REPEAT = 2'b11
   } xfer_mode_e;

   typedef enum logic [1:0] {
      ENG_IDLE  = 2'd0,
      ENG_READ  = 2'd1,
      ENG_WRITE = 2'd2
   } eng_state_e;

   localparam int IDX_CTRL   = 0;
   localparam int IDX_COUNT  = 1;
   localparam int IDX_RELOAD = 2;
   localparam int IDX_SRC    = 3;
   localparam int IDX_DST    = 4;

   localparam int CTL_MODE_LO = 5;
   localparam int CTL_MODE_HI = 6;
   localparam int CTL_WIDE    = 7;
   localparam int CTL_SINC    = 8;
   localparam int CTL_DINC    = 9;
   localparam int CTL_KICK    = 10;
   localparam int CTL_SEL_MAX = 5;

   localparam int UNIT_W = 16;
endpackage

// File: rtl/dma4_chan_regs.sv
`timescale 1ns/1ps
module dma4_chan_regs
   import dma4_pkg::*;
#(
   parameter int AW       = 24,
   parameter int CW       = 16,
   parameter int SEL_W    = 5,
   parameter int NUM_PREQ = 8,
   parameter int SW_SEL   = 31,
   parameter int RDW      = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       idx,
   input  logic [RDW-1:0]   wdata,
   input  logic [NUM_PREQ-1:0] preq,
   input  logic             start_i,
   input  logic             done_i,
   output logic             eligible_o,
   output logic             cfg_err_o,
   output logic             wide_o,
   output logic [AW-1:0]    src_o,
   output logic [AW-1:0]    dst_o,
   output logic             irq_o,
   output logic [RDW-1:0]   rdword_o
);
   localparam logic [SEL_W-1:0] SW_CODE = SEL_W'(SW_SEL);

   generate
      if (SEL_W > CTL_SEL_MAX) begin : g_bad_sel
         $error("SEL_W exceeds the control field");
      end
      if (SW_SEL < NUM_PREQ || SW_SEL >= (1 << SEL_W)) begin : g_bad_sw
         $error("SW_SEL must lie above the peripheral codes");
      end
      if (RDW < AW || RDW < CW || RDW <= CTL_KICK) begin : g_bad_rdw
         $error("RDW too narrow");
      end
   endgenerate

   logic [SEL_W-1:0] sel_q;
   xfer_mode_e       mode_q;
   logic             wide_q, sinc_q, dinc_q, pend_q, irq_q;
   logic [CW-1:0]    cnt_q, rld_q;
   logic [AW-1:0]    src_q, dst_q;

   logic             enabled, legal, active, kick, preq_hit, hit;
   logic [AW-1:0]    step;

   assign enabled = (mode_q == MODE_SINGLE) || (mode_q == MODE_REPEAT);
   assign legal   = sinc_q ^ dinc_q;
   assign active  = enabled && legal && (cnt_q != '0);
   assign step    = wide_q ? AW'(2) : AW'(1);

   assign kick = wr_en && (idx == 3'(IDX_CTRL)) && wdata[CTL_KICK]
                 && (wdata[SEL_W-1:0] == SW_CODE);

   always_comb begin
      preq_hit = 1'b0;
      for (int k = 0; k < NUM_PREQ; k++) begin
         if (sel_q == SEL_W'(k)) preq_hit = preq[k];
      end
   end

   assign hit = kick || preq_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         mode_q <= MODE_OFF;
         wide_q <= 1'b0;
         sinc_q <= 1'b0;
         dinc_q <= 1'b0;
         pend_q <= 1'b0;
         irq_q  <= 1'b0;
         cnt_q  <= '0;
         rld_q  <= '0;
         src_q  <= '0;
         dst_q  <= '0;
      end else begin
         irq_q  <= 1'b0;
         pend_q <= active ? ((pend_q && !start_i) || hit) : hit;
         if (done_i) begin
            if (cnt_q == CW'(1)) begin
               irq_q <= 1'b1;
               cnt_q <= (mode_q == MODE_REPEAT) ? rld_q : '0;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
            if (sinc_q) src_q <= src_q + step;
            if (dinc_q) dst_q <= dst_q + step;
         end
         if (wr_en) begin
            case (idx)
               3'(IDX_CTRL): begin
                  sel_q  <= wdata[SEL_W-1:0];
                  mode_q <= xfer_mode_e'(wdata[CTL_MODE_HI:CTL_MODE_LO]);
                  wide_q <= wdata[CTL_WIDE];
                  sinc_q <= wdata[CTL_SINC];
                  dinc_q <= wdata[CTL_DINC];
               end
               3'(IDX_COUNT): begin
                  if (wdata[CW-1:0] == '0 && mode_q == MODE_REPEAT)
                     cnt_q <= rld_q;
                  else
                     cnt_q <= wdata[CW-1:0];
               end
               3'(IDX_RELOAD): rld_q <= wdata[CW-1:0];
               3'(IDX_SRC):    src_q <= wdata[AW-1:0];
               3'(IDX_DST):    dst_q <= wdata[AW-1:0];
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      rdword_o = '0;
      case (idx)
         3'(IDX_CTRL): begin
            rdword_o[SEL_W-1:0]               = sel_q;
            rdword_o[CTL_MODE_HI:CTL_MODE_LO] = mode_q;
            rdword_o[CTL_WIDE]                = wide_q;
            rdword_o[CTL_SINC]                = sinc_q;
            rdword_o[CTL_DINC]                = dinc_q;
         end
         3'(IDX_COUNT):  rdword_o[CW-1:0] = cnt_q;
         3'(IDX_RELOAD): rdword_o[CW-1:0] = rld_q;
         3'(IDX_SRC):    rdword_o[AW-1:0] = src_q;
         3'(IDX_DST):    rdword_o[AW-1:0] = dst_q;
         default: ;
      endcase
   end

   assign eligible_o = pend_q && active;
   assign cfg_err_o  = enabled && !legal;
   assign wide_o     = wide_q;
   assign src_o      = src_q;
   assign dst_o      = dst_q;
   assign irq_o      = irq_q;
endmodule

// File: rtl/dma4_prio_arb.sv
`timescale 1ns/1ps
module dma4_prio_arb #(
   parameter int N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_lvl
         if (i == 0) begin : g_top
            assign grant[i] = req[i];
         end else begin : g_rest
            assign grant[i] = req[i] && !(|req[i-1:0]);
         end
      end
   endgenerate
endmodule

// File: rtl/dma4_xfer_engine.sv
`timescale 1ns/1ps
module dma4_xfer_engine
   import dma4_pkg::*;
#(
   parameter int N   = 4,
   parameter int AW  = 24,
   parameter int CHW = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N-1:0]      grant,
   input  logic [AW-1:0]     src_addr,
   input  logic [AW-1:0]     dst_addr,
   input  logic              wide,
   output logic [N-1:0]      start_o,
   output logic [N-1:0]      done_o,
   output logic [CHW-1:0]    cur_ch,
   output logic              bus_req,
   output logic              bus_we,
   output logic              bus_wide,
   output logic [AW-1:0]     bus_addr,
   output logic [UNIT_W-1:0] bus_wdata,
   input  logic [UNIT_W-1:0] bus_rdata,
   input  logic              bus_ready
);
   localparam int HALF = UNIT_W / 2;

   eng_state_e        st_q;
   logic [CHW-1:0]    ch_q, win_idx;
   logic [UNIT_W-1:0] data_q;

   always_comb begin
      win_idx = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (grant[k]) win_idx = CHW'(k);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ENG_IDLE;
         ch_q   <= '0;
         data_q <= '0;
      end else begin
         case (st_q)
            ENG_IDLE: begin
               if (|grant) begin
                  ch_q <= win_idx;
                  st_q <= ENG_READ;
               end
            end
            ENG_READ: begin
               if (bus_ready) begin
                  data_q <= wide ? bus_rdata : {{HALF{1'b0}}, bus_rdata[HALF-1:0]};
                  st_q   <= ENG_WRITE;
               end
            end
            ENG_WRITE: begin
               if (bus_ready) st_q <= ENG_IDLE;
            end
            default: st_q <= ENG_IDLE;
         endcase
      end
   end

   always_comb begin
      start_o = (st_q == ENG_IDLE) ? grant : '0;
      done_o  = '0;
      if (st_q == ENG_WRITE && bus_ready) done_o[ch_q] = 1'b1;
   end

   assign cur_ch    = ch_q;
   assign bus_req   = (st_q == ENG_READ) || (st_q == ENG_WRITE);
   assign bus_we    = (st_q == ENG_WRITE);
   assign bus_wide  = wide;
   assign bus_addr  = (st_q == ENG_WRITE) ? dst_addr : src_addr;
   assign bus_wdata = data_q;
endmodule

// File: rtl/dma4_steal.sv
`timescale 1ns/1ps
module dma4_steal
   import dma4_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int AW       = 24,
   parameter int CW       = 16,
   parameter int SEL_W    = 5,
   parameter int NUM_PREQ = 8,
   parameter int SW_SEL   = 31,
   parameter int RDW      = 32,
   localparam int CHW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int RAW     = CHW + 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [RAW-1:0]      reg_addr,
   input  logic [RDW-1:0]      reg_wdata,
   output logic [RDW-1:0]      reg_rdata,
   input  logic [NUM_PREQ-1:0] periph_req,
   output logic                bus_req,
   output logic                bus_we,
   output logic                bus_wide,
   output logic [AW-1:0]       bus_addr,
   output logic [UNIT_W-1:0]   bus_wdata,
   input  logic [UNIT_W-1:0]   bus_rdata,
   input  logic                bus_ready,
   output logic [NUM_CH-1:0]   irq,
   output logic [NUM_CH-1:0]   cfg_err
);
   generate
      if (NUM_CH < 2 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_ch
         $error("NUM_CH must be a power of two, at least 2");
      end
   endgenerate

   logic [CHW-1:0]  reg_ch, cur_ch;
   logic [2:0]      reg_idx;
   logic [NUM_CH-1:0] elig_vec, grant_vec, start_vec, done_vec, wide_vec;
   logic [AW-1:0]   src_a [NUM_CH];
   logic [AW-1:0]   dst_a [NUM_CH];
   logic [RDW-1:0]  rdw_a [NUM_CH];

   assign reg_ch  = reg_addr[RAW-1:3];
   assign reg_idx = reg_addr[2:0];

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         dma4_chan_regs #(
            .AW(AW), .CW(CW), .SEL_W(SEL_W), .NUM_PREQ(NUM_PREQ),
            .SW_SEL(SW_SEL), .RDW(RDW)
         ) i_regs (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (reg_we && (reg_ch == CHW'(i))),
            .idx        (reg_idx),
            .wdata      (reg_wdata),
            .preq       (periph_req),
            .start_i    (start_vec[i]),
            .done_i     (done_vec[i]),
            .eligible_o (elig_vec[i]),
            .cfg_err_o  (cfg_err[i]),
            .wide_o     (wide_vec[i]),
            .src_o      (src_a[i]),
            .dst_o      (dst_a[i]),
            .irq_o      (irq[i]),
            .rdword_o   (rdw_a[i])
         );
      end
   endgenerate

   assign reg_rdata = rdw_a[reg_ch];

   dma4_prio_arb #(.N(NUM_CH)) i_arb (
      .req   (elig_vec),
      .grant (grant_vec)
   );

   dma4_xfer_engine #(.N(NUM_CH), .AW(AW), .CHW(CHW)) i_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .grant     (grant_vec),
      .src_addr  (src_a[cur_ch]),
      .dst_addr  (dst_a[cur_ch]),
      .wide      (wide_vec[cur_ch]),
      .start_o   (start_vec),
      .done_o    (done_vec),
      .cur_ch    (cur_ch),
      .bus_req   (bus_req),
      .bus_we    (bus_we),
      .bus_wide  (bus_wide),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .bus_ready (bus_ready)
   );
endmodule

// File: rtl/dma4_steal_chk.sv
`timescale 1ns/1ps
module dma4_steal_chk #(
   parameter int NUM_CH = 4,
   parameter int AW     = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] start_vec,
   input logic [NUM_CH-1:0] elig_vec,
   input logic [NUM_CH-1:0] cfg_err,
   input logic [NUM_CH-1:0] irq,
   input logic              bus_req,
   input logic              bus_we,
   input logic              bus_ready,
   input logic [AW-1:0]     bus_addr
);
   a_r2_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
      (start_vec != '0) |-> (((start_vec - 1'b1) & elig_vec) == '0));

   a_r8_bad_cfg_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (start_vec & cfg_err) == '0);

   a_r9_irq_single_chan: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq));

   a_r9_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (irq != '0) |=> (irq == '0));

   a_r6_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

   a_r6_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we && bus_ready) |=> (bus_req && bus_we));

   a_r6_release_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && bus_ready) |=> !bus_req);
endmodule

bind dma4_steal dma4_steal_chk #(.NUM_CH(NUM_CH), .AW(AW)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_vec (start_vec),
   .elig_vec  (elig_vec),
   .cfg_err   (cfg_err),
   .irq       (irq),
   .bus_req   (bus_req),
   .bus_we    (bus_we),
   .bus_ready (bus_ready),
   .bus_addr  (bus_addr)
);

// File: tb/test_dma4_steal.sv
`timescale 1ns/1ps
module test_dma4_steal;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [7:0]  periph_req = '0;
   logic        bus_req, bus_we, bus_wide, bus_ready;
   logic [23:0] bus_addr;
   logic [15:0] bus_wdata, bus_rdata;
   logic [3:0]  irq, cfg_err;
   logic        stall = 1'b0;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   assign bus_ready = bus_req && !stall;
   assign bus_rdata = {~bus_addr[7:0], bus_addr[7:0]};

   dma4_steal i_dma4_steal (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
      .bus_req(bus_req), .bus_we(bus_we), .bus_wide(bus_wide),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ready(bus_ready), .irq(irq), .cfg_err(cfg_err)
   );

   int          wr_tot = 0;
   logic [23:0] wr_addr_log [16];
   logic [15:0] last_wdata = '0;
   int          irq_tot [4];

   always @(posedge clk) begin
      if (bus_req && bus_we && bus_ready) begin
         wr_addr_log[wr_tot % 16] <= bus_addr;
         last_wdata <= bus_wdata;
         wr_tot <= wr_tot + 1;
      end
      for (int i = 0; i < 4; i++) if (irq[i]) irq_tot[i] <= irq_tot[i] + 1;
   end

   typedef struct packed {
      logic [1:0]  ch;
      logic [10:0] ctrl;
      logic [15:0] cnt;
      logic [15:0] rld;
      logic [23:0] src;
      logic [23:0] dst;
      logic [3:0]  ntrig;
      logic [15:0] ecnt;
      logic [23:0] esrc;
      logic [23:0] edst;
      logic [3:0]  eirq;
      logic [3:0]  ewr;
   } vec_t;

   // ctrl: sel[4:0], mode[6:5], wide[7], src advance[8], dst advance[9]
   localparam vec_t VECS [7] = '{
      '{2'd0, 11'h13F, 16'd3, 16'd0, 24'h000100, 24'h000200, 4'd2, 16'd1, 24'h000102, 24'h000200, 4'd0, 4'd2}, // R7 R9 narrow single
      '{2'd1, 11'h2BF, 16'd2, 16'd0, 24'h000040, 24'h000300, 4'd3, 16'd0, 24'h000040, 24'h000304, 4'd1, 4'd2}, // R10 single stops
      '{2'd2, 11'h27F, 16'd2, 16'd2, 24'h000050, 24'h000010, 4'd3, 16'd1, 24'h000050, 24'h000013, 4'd1, 4'd3}, // R10 repeat reload
      '{2'd3, 11'h1BF, 16'd1, 16'd0, 24'hFFFFFF, 24'h000020, 4'd1, 16'd0, 24'h000001, 24'h000020, 4'd1, 4'd1}, // R7 wrap
      '{2'd0, 11'h15F, 16'd5, 16'd0, 24'h000100, 24'h000200, 4'd2, 16'd5, 24'h000100, 24'h000200, 4'd0, 4'd0}, // R5 mode 10
      '{2'd1, 11'h33F, 16'd4, 16'd0, 24'h000010, 24'h000020, 4'd1, 16'd4, 24'h000010, 24'h000020, 4'd0, 4'd0}, // R8 both advance
      '{2'd0, 11'h17F, 16'd1, 16'd3, 24'h000000, 24'h000400, 4'd2, 16'd2, 24'h000002, 24'h000400, 4'd1, 4'd2}  // R3 R10 repeat
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] ch, input int idx, input logic [31:0] d);
      @(negedge clk);
      reg_addr  = {ch, 3'(idx)};
      reg_wdata = d;
      reg_we    = 1'b1;
      @(negedge clk);
      reg_we    = 1'b0;
   endtask

   task automatic rd(input logic [1:0] ch, input int idx, output logic [31:0] d);
      reg_addr = {ch, 3'(idx)};
      #1 d = reg_rdata;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      summary();
   end

   initial begin
      logic [31:0] d;
      int w0, i0, base;
      for (int i = 0; i < 4; i++) irq_tot[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 bus_req", 32'(bus_req), 32'd0);
      chk("R1 irq", 32'(irq), 32'd0);
      chk("R1 cfg_err", 32'(cfg_err), 32'd0);
      for (int c = 0; c < 4; c++) begin
         rd(2'(c), 0, d); chk("R1 ctrl", d, 32'd0);
         rd(2'(c), 1, d); chk("R1 count", d, 32'd0);
      end

      // vector table
      for (int v = 0; v < 7; v++) begin
         vec_t t;
         logic err_exp;
         t = VECS[v];
         wr(t.ch, 3, 32'(t.src));
         wr(t.ch, 4, 32'(t.dst));
         wr(t.ch, 2, 32'(t.rld));
         wr(t.ch, 1, 32'(t.cnt));
         wr(t.ch, 0, 32'(t.ctrl));
         w0 = wr_tot;
         i0 = irq_tot[t.ch];
         for (int k = 0; k < int'(t.ntrig); k++) begin
            wr(t.ch, 0, 32'(t.ctrl) | 32'h400);
            settle(8);
         end
         rd(t.ch, 1, d); chk("R9 R10 count", d, 32'(t.ecnt));
         rd(t.ch, 3, d); chk("R7 src", d, 32'(t.esrc));
         rd(t.ch, 4, d); chk("R7 dst", d, 32'(t.edst));
         chk("R9 irq pulses", 32'(irq_tot[t.ch] - i0), 32'(t.eirq));
         chk("R5 R8 writes", 32'(wr_tot - w0), 32'(t.ewr));
         err_exp = (t.ctrl[8] == t.ctrl[9]) && t.ctrl[5];
         chk("R8 cfg_err", 32'(cfg_err[t.ch]), 32'(err_exp));
      end
      for (int c = 0; c < 4; c++) wr(2'(c), 0, 32'd0);

      // R2 priority with R3 peripheral mapping: ch0 sel2, ch1 sel0, ch2 sel1
      for (int c = 0; c < 3; c++) begin
         wr(2'(c), 3, 32'h80);
         wr(2'(c), 4, 32'hA00 + 32'(c * 16));
         wr(2'(c), 1, 32'd1);
      end
      wr(2'd0, 0, 32'h122);
      wr(2'd1, 0, 32'h120);
      wr(2'd2, 0, 32'h121);
      base = wr_tot;
      @(negedge clk); periph_req = 8'h07;
      @(negedge clk); periph_req = 8'h00;
      settle(20);
      chk("R2 writes", 32'(wr_tot - base), 32'd3);
      chk("R2 first ch0", 32'(wr_addr_log[(base + 0) % 16]), 32'hA00);
      chk("R2 second ch1", 32'(wr_addr_log[(base + 1) % 16]), 32'hA10);
      chk("R2 third ch2", 32'(wr_addr_log[(base + 2) % 16]), 32'hA20);
      for (int c = 0; c < 3; c++) wr(2'(c), 0, 32'd0);

      // R4 merge and R6 wait states: ch3, sel 3, fixed src, advancing dst
      wr(2'd3, 3, 32'h700);
      wr(2'd3, 4, 32'hB00);
      wr(2'd3, 1, 32'd5);
      wr(2'd3, 0, 32'h223);
      base = wr_tot;
      stall = 1'b1;
      @(negedge clk); periph_req = 8'h08;
      @(negedge clk); periph_req = 8'h00;
      settle(2);
      chk("R6 read held", 32'(bus_req && !bus_we), 32'd1);
      chk("R6 read addr", 32'(bus_addr), 32'h700);
      periph_req = 8'h08; @(negedge clk); periph_req = 8'h00;
      settle(2);
      periph_req = 8'h08; @(negedge clk); periph_req = 8'h00;
      settle(2);
      chk("R6 still held", 32'(bus_addr), 32'h700);
      stall = 1'b0;
      settle(20);
      rd(2'd3, 1, d); chk("R4 merged count", d, 32'd3);
      chk("R4 merged writes", 32'(wr_tot - base), 32'd2);
      wr(2'd3, 0, 32'd0);

      // R7 data lanes: narrow then wide from fixed src 0x3C
      wr(2'd1, 3, 32'h3C);
      wr(2'd1, 4, 32'h500);
      wr(2'd1, 1, 32'd2);
      wr(2'd1, 0, 32'h23F | 32'h400);
      settle(8);
      chk("R7 narrow data", 32'(last_wdata), 32'h003C);
      wr(2'd1, 0, 32'h2BF | 32'h400);
      settle(8);
      chk("R7 wide data", 32'(last_wdata), 32'hC33C);
      chk("R7 wide dst", 32'(wr_addr_log[(wr_tot - 1) % 16]), 32'h501);
      wr(2'd1, 0, 32'd0);

      // R11 software zero writes
      wr(2'd2, 2, 32'd3);
      wr(2'd2, 0, 32'h17F);
      wr(2'd2, 1, 32'd5);
      wr(2'd2, 1, 32'd0);
      rd(2'd2, 1, d); chk("R11 repeat reload", d, 32'd3);
      wr(2'd2, 2, 32'd0);
      wr(2'd2, 1, 32'd0);
      rd(2'd2, 1, d); chk("R11 repeat stop", d, 32'd0);
      base = wr_tot;
      wr(2'd2, 0, 32'h17F | 32'h400);
      settle(8);
      chk("R11 repeat no xfer", 32'(wr_tot - base), 32'd0);
      wr(2'd0, 0, 32'h13F);
      wr(2'd0, 1, 32'd4);
      wr(2'd0, 1, 32'd0);
      base = wr_tot;
      wr(2'd0, 0, 32'h13F | 32'h400);
      settle(8);
      rd(2'd0, 1, d); chk("R11 single stop", d, 32'd0);
      chk("R11 single no xfer", 32'(wr_tot - base), 32'd0);
      wr(2'd0, 0, 32'd0);
      wr(2'd2, 0, 32'd0);

      // R6 R9 cycle timing on ch3
      wr(2'd3, 3, 32'h10);
      wr(2'd3, 4, 32'h20);
      wr(2'd3, 1, 32'd1);
      wr(2'd3, 0, 32'h13F);
      wr(2'd3, 0, 32'h13F | 32'h400);
      @(negedge clk);
      chk("R6 read phase", 32'({bus_req, bus_we}), 32'b10);
      @(negedge clk);
      chk("R6 write phase", 32'({bus_req, bus_we}), 32'b11);
      chk("R6 write addr", 32'(bus_addr), 32'h20);
      @(negedge clk);
      chk("R9 irq pulse", 32'(irq), 32'b1000);
      chk("R6 bus released", 32'(bus_req), 32'd0);
      @(negedge clk);
      chk("R9 irq cleared", 32'(irq), 32'd0);

      summary();
   end
endmodule